// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block sits between a simple CPU-style register bus and the priority logic of an eight-level interrupt controller. Each clock cycle in which chip select and the write strobe are both high counts as one write of an 8-bit byte at one of two addresses, chosen by the single address bit `a0_i`. The block runs the setup sequence. That sequence has two, three or four words, depending on the cascade and fourth-word flags in its first word. After setup, the block steers each write to the mask register or to one of the two run-time command words.

Its outputs are decoded configuration and control signals:
- trigger mode
- single or cascade operation
- vector base
- cascade configuration byte
- the five fourth-word flags
- the mask
- special mask mode
- read-select state
- one-cycle pulses for end-of-interrupt/rotate commands and for poll requests

On a read, a small multiplexer drives the request, in-service or mask register onto the read data bus. The priority resolver and the acknowledge cycle live outside this block.

Top module: `icd_cmd_decoder`

## Requirements
- R1: After reset `init_done_o` is 0, and every configuration output, the mask, `smm_o`, `ris_o` and all pulses are 0.
- R2: A write with `a0_i`=0 and data bit 4 set always restarts setup, from any state. It loads `level_trig_o` from bit 3, `single_o` from bit 1 and the fourth-word flag from bit 0. It clears all fourth-word outputs and drops `init_done_o`.
- R3: The next `a0_i`=1 write after the first word loads `vec_base_o` from data bits 7..3.
- R4: A third word is expected only when `single_o` is 0. The next `a0_i`=1 write then loads `cas_cfg_o` with the whole byte.
- R5: A fourth word is expected only when the fourth-word flag was 1. It loads `sfnm_o`=bit 4, `buffered_o`=bit 3, `master_o`=bit 2, `aeoi_o`=bit 1 and `cpu_mode_o`=bit 0. Otherwise those outputs stay cleared.
- R6: `init_done_o` rises in the cycle after the last expected setup word. After that, an `a0_i`=1 write loads `mask_o` with the byte.
- R7: After setup, a write with `a0_i`=0, bit 4=0 and bit 3=0 raises `cmd_valid_o` for exactly one cycle. Alongside it, `cmd_rotate_o`=bit 7, `cmd_select_o`=bit 6, `cmd_eoi_o`=bit 5 and `cmd_level_o`=bits 2..0.
- R8: After setup, a write with `a0_i`=0, bit 4=0 and bit 3=1 does three things. It loads `smm_o` from bit 5 only if bit 6 is 1. It loads `ris_o` from bit 0 only if bit 1 is 1. It raises `poll_o` for one cycle when bit 2 is 1.
- R9: While `cs_i` and `rd_i` are high, `rdata_o` is `mask_o` when `a0_i`=1, `irr_i` when `a0_i`=0 and `ris_o`=0, and `isr_i` when `a0_i`=0 and `ris_o`=1. It is 0 when no read is selected.
- R10: Writes with `cs_i` low change nothing. Before the first setup word, writes to mask or command words change nothing.
- R11: During setup, a write with `a0_i`=0 and bit 4 clear is ignored and does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write strobe, one write per cycle |
| rd_i | input | 1 | Read strobe |
| a0_i | input | 1 | Address bit |
| wdata_i | input | 8 | Write data byte |
| irr_i | input | 8 | Request register from priority logic |
| isr_i | input | 8 | In-service register from priority logic |
| rdata_o | output | 8 | Read data |
| init_done_o | output | 1 | Setup sequence complete |
| level_trig_o | output | 1 | 1 = level triggered, 0 = edge |
| single_o | output | 1 | 1 = single controller, 0 = cascade |
| vec_base_o | output | 5 | Upper bits of the interrupt type |
| cas_cfg_o | output | 8 | Cascade configuration byte |
| sfnm_o | output | 1 | Special fully nested mode |
| buffered_o | output | 1 | Buffered bus mode |
| master_o | output | 1 | Master in buffered mode |
| aeoi_o | output | 1 | Automatic end of interrupt |
| cpu_mode_o | output | 1 | Processor mode bit |
| mask_o | output | 8 | Interrupt mask |
| cmd_valid_o | output | 1 | Command pulse |
| cmd_rotate_o | output | 1 | Rotate flag of the command |
| cmd_select_o | output | 1 | Specific-level flag of the command |
| cmd_eoi_o | output | 1 | End-of-interrupt flag of the command |
| cmd_level_o | output | 3 | Level field of the command |
| smm_o | output | 1 | Special mask mode |
| ris_o | output | 1 | Read select: 1 = in-service, 0 = request |
| poll_o | output | 1 | Poll request pulse |

## Verification
The bench targets how the sequence length changes. It runs single with no fourth word, single with a fourth word, and cascade with both. A design that skips the wrong word would put the vector or mask byte into the wrong register. A first-word write in mid-sequence must restart setup. A design that treats it as data would leave `init_done_o` high or keep old fourth-word flags. The bench also sends command-word writes during setup and mask writes before any setup. A decoder that lets them through would pulse commands or alter the mask. The enable bits of the third command word are exercised with each enable both clear and set, which catches a design that updates special mask mode or read select unconditionally.

// File: rtl/icd_pkg.sv
package icd_pkg;
  typedef enum logic [2:0] {
    SEQ_UNINIT = 3'd0,
    SEQ_W2     = 3'd1,
    SEQ_W3     = 3'd2,
    SEQ_W4     = 3'd3,
    SEQ_READY  = 3'd4
  } seq_e;

  typedef struct packed {
    logic       rot;
    logic       sel;
    logic       eoi;
    logic [2:0] lvl;
  } op_cmd_t;
endpackage

// File: rtl/icd_init_seq.sv
module icd_init_seq
  import icd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LVL_W = 3,
  localparam int VB_W = DW - LVL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            a0_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            init_done_o,
  output logic            level_trig_o,
  output logic            single_o,
  output logic [VB_W-1:0] vec_base_o,
  output logic [DW-1:0]   cas_cfg_o,
  output logic [4:0]      w4_flags_o
);
  seq_e state_q;
  logic need_w4_q;
  logic start_w;

  assign start_w     = wr_en_i && !a0_i && wdata_i[4];
  assign init_done_o = (state_q == SEQ_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= SEQ_UNINIT;
      need_w4_q    <= 1'b0;
      level_trig_o <= 1'b0;
      single_o     <= 1'b0;
      vec_base_o   <= '0;
      cas_cfg_o    <= '0;
      w4_flags_o   <= '0;
    end else if (start_w) begin
      level_trig_o <= wdata_i[3];
      single_o     <= wdata_i[1];
      need_w4_q    <= wdata_i[0];
      w4_flags_o   <= '0;
      state_q      <= SEQ_W2;
    end else if (wr_en_i && a0_i) begin
      unique case (state_q)
        SEQ_W2: begin
          vec_base_o <= wdata_i[DW-1:LVL_W];
          if (!single_o)      state_q <= SEQ_W3;
          else if (need_w4_q) state_q <= SEQ_W4;
          else                state_q <= SEQ_READY;
        end
        SEQ_W3: begin
          cas_cfg_o <= wdata_i;
          state_q   <= need_w4_q ? SEQ_W4 : SEQ_READY;
        end
        SEQ_W4: begin
          w4_flags_o <= wdata_i[4:0];
          state_q    <= SEQ_READY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/icd_op_words.sv
module icd_op_words
  import icd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          a0_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          init_done_i,
  output logic [DW-1:0] mask_o,
  output logic          cmd_valid_o,
  output op_cmd_t       cmd_o,
  output logic          smm_o,
  output logic          ris_o,
  output logic          poll_o
);
  logic run_wr, ctl_wr;

  assign run_wr = wr_en_i && init_done_i;
  assign ctl_wr = run_wr && !a0_i && !wdata_i[4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
      smm_o       <= 1'b0;
      ris_o       <= 1'b0;
      poll_o      <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      poll_o      <= 1'b0;
      if (run_wr && a0_i) mask_o <= wdata_i;
      if (ctl_wr && !wdata_i[3]) begin
        cmd_valid_o <= 1'b1;
        cmd_o       <= '{rot: wdata_i[7], sel: wdata_i[6], eoi: wdata_i[5],
                         lvl: wdata_i[2:0]};
      end
      if (ctl_wr && wdata_i[3]) begin
        if (wdata_i[6]) smm_o <= wdata_i[5];
        if (wdata_i[1]) ris_o <= wdata_i[0];
        poll_o <= wdata_i[2];
      end
    end
  end
endmodule

// File: rtl/icd_read_mux.sv
module icd_read_mux #(
  parameter int DW = 8
) (
  input  logic          rd_en_i,
  input  logic          a0_i,
  input  logic          ris_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    if (!rd_en_i)   rdata_o = '0;
    else if (a0_i)  rdata_o = mask_i;
    else if (ris_i) rdata_o = isr_i;
    else            rdata_o = irr_i;
  end
endmodule

// File: rtl/icd_cmd_decoder.sv
module icd_cmd_decoder
  import icd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LVL_W = 3,
  localparam int VB_W = DW - LVL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic            a0_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   irr_i,
  input  logic [DW-1:0]   isr_i,
  output logic [DW-1:0]   rdata_o,
  output logic            init_done_o,
  output logic            level_trig_o,
  output logic            single_o,
  output logic [VB_W-1:0] vec_base_o,
  output logic [DW-1:0]   cas_cfg_o,
  output logic            sfnm_o,
  output logic            buffered_o,
  output logic            master_o,
  output logic            aeoi_o,
  output logic            cpu_mode_o,
  output logic [DW-1:0]   mask_o,
  output logic            cmd_valid_o,
  output logic            cmd_rotate_o,
  output logic            cmd_select_o,
  output logic            cmd_eoi_o,
  output logic [LVL_W-1:0] cmd_level_o,
  output logic            smm_o,
  output logic            ris_o,
  output logic            poll_o
);
  logic       wr_en, rd_en;
  logic [4:0] w4_flags;
  op_cmd_t    cmd;

  assign wr_en = cs_i && wr_i;
  assign rd_en = cs_i && rd_i;

  icd_init_seq #(.DW(DW), .LVL_W(LVL_W)) u_init (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .a0_i, .wdata_i,
    .init_done_o, .level_trig_o, .single_o, .vec_base_o, .cas_cfg_o,
    .w4_flags_o(w4_flags)
  );

  assign {sfnm_o, buffered_o, master_o, aeoi_o, cpu_mode_o} = w4_flags;

  icd_op_words #(.DW(DW)) u_ops (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .a0_i, .wdata_i,
    .init_done_i(init_done_o), .mask_o, .cmd_valid_o, .cmd_o(cmd),
    .smm_o, .ris_o, .poll_o
  );

  assign cmd_rotate_o = cmd.rot;
  assign cmd_select_o = cmd.sel;
  assign cmd_eoi_o    = cmd.eoi;
  assign cmd_level_o  = cmd.lvl;

  icd_read_mux #(.DW(DW)) u_rd (
    .rd_en_i(rd_en), .a0_i, .ris_i(ris_o), .irr_i, .isr_i,
    .mask_i(mask_o), .rdata_o
  );
endmodule

// File: rtl/icd_checker.sv
module icd_checker #(
  parameter int DW    = 8,
  parameter int LVL_W = 3,
  localparam int VB_W = DW - LVL_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic            a0_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   irr_i,
  input logic [DW-1:0]   isr_i,
  input logic [DW-1:0]   rdata_o,
  input logic            init_done_o,
  input logic            level_trig_o,
  input logic            single_o,
  input logic [VB_W-1:0] vec_base_o,
  input logic [DW-1:0]   cas_cfg_o,
  input logic            sfnm_o,
  input logic            buffered_o,
  input logic            master_o,
  input logic            aeoi_o,
  input logic            cpu_mode_o,
  input logic [DW-1:0]   mask_o,
  input logic            cmd_valid_o,
  input logic            cmd_rotate_o,
  input logic            cmd_select_o,
  input logic            cmd_eoi_o,
  input logic [LVL_W-1:0] cmd_level_o,
  input logic            smm_o,
  input logic            ris_o,
  input logic            poll_o
);
  p_first_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !a0_i && wdata_i[4]) |=>
      (!init_done_o && level_trig_o == $past(wdata_i[3]) &&
       single_o == $past(wdata_i[1]) && !aeoi_o && !sfnm_o));

  p_mask_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && a0_i && init_done_o) |=> (mask_o == $past(wdata_i)));

  p_cmd_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(cs_i && wr_i && !a0_i && !wdata_i[4] &&
                          !wdata_i[3] && init_done_o));

  p_poll_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_o |-> $past(cs_i && wr_i && !a0_i && wdata_i[3:2] == 2'b11 &&
                     !wdata_i[4] && init_done_o));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i) |=> ($stable(mask_o) && $stable(vec_base_o) &&
                         $stable(init_done_o) && !cmd_valid_o && !poll_o));

  p_read_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && a0_i) |-> (rdata_o == mask_o));
endmodule

bind icd_cmd_decoder icd_checker #(.DW(DW), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/icd_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module icd_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0, a0 = 0;
  logic [7:0] wd = 0, irr = 0, isr = 0;
  logic [7:0] rdata, cas, mask;
  logic [4:0] vb;
  logic [2:0] lvl;
  logic done, ltim, sngl, sfnm, bufm, mst, aeoi, upm, cv, crot, csel, ceoi, smm, ris, poll;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  icd_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd), .a0_i(a0),
    .wdata_i(wd), .irr_i(irr), .isr_i(isr), .rdata_o(rdata),
    .init_done_o(done), .level_trig_o(ltim), .single_o(sngl), .vec_base_o(vb),
    .cas_cfg_o(cas), .sfnm_o(sfnm), .buffered_o(bufm), .master_o(mst),
    .aeoi_o(aeoi), .cpu_mode_o(upm), .mask_o(mask), .cmd_valid_o(cv),
    .cmd_rotate_o(crot), .cmd_select_o(csel), .cmd_eoi_o(ceoi),
    .cmd_level_o(lvl), .smm_o(smm), .ris_o(ris), .poll_o(poll)
  );

  // behavioural reference
  int m_st, m_ic4, m_ltim, m_sngl, m_vb, m_cas, m_w4, m_mask;
  int m_cv, m_cmd, m_smm, m_ris, m_poll;

  task automatic m_reset();
    m_st = 0; m_ic4 = 0; m_ltim = 0; m_sngl = 0; m_vb = 0; m_cas = 0; m_w4 = 0;
    m_mask = 0; m_cv = 0; m_cmd = 0; m_smm = 0; m_ris = 0; m_poll = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      m_cv = 0; m_poll = 0;
      if (cs && wr) begin
        if (!a0 && wd[4]) begin
          m_ltim = wd[3]; m_sngl = wd[1]; m_ic4 = wd[0]; m_w4 = 0; m_st = 1;
        end else if (m_st == 1 && a0) begin
          m_vb = wd >> 3;
          m_st = (m_sngl == 0) ? 2 : (m_ic4 != 0) ? 3 : 4;
        end else if (m_st == 2 && a0) begin
          m_cas = wd; m_st = (m_ic4 != 0) ? 3 : 4;
        end else if (m_st == 3 && a0) begin
          m_w4 = wd & 8'h1F; m_st = 4;
        end else if (m_st == 4) begin
          if (a0) m_mask = wd;
          else if (!wd[3]) begin m_cv = 1; m_cmd = {wd[7:5], wd[2:0]}; end
          else begin
            if (wd[6]) m_smm = wd[5];
            if (wd[1]) m_ris = wd[0];
            m_poll = wd[2];
          end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    int exp_rd;
    chk("R2 init_done", done, m_st == 4);
    chk("R2 level_trig", ltim, m_ltim);
    chk("R2 single", sngl, m_sngl);
    chk("R3 vec_base", vb, m_vb);
    chk("R4 cas_cfg", cas, m_cas);
    chk("R5 w4 flags", {sfnm, bufm, mst, aeoi, upm}, m_w4);
    chk("R6 mask", mask, m_mask);
    chk("R7 cmd_valid", cv, m_cv);
    if (m_cv != 0) chk("R7 cmd fields", {crot, csel, ceoi, lvl}, m_cmd);
    chk("R8 smm/ris/poll", {smm, ris, poll}, {m_smm[0], m_ris[0], m_poll[0]});
    exp_rd = !(cs && rd) ? 0 : a0 ? m_mask : m_ris ? isr : irr;
    chk("R9 rdata", rdata, exp_rd);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); cmp_all();
  endtask

  task automatic wr_b(logic a, logic [7:0] d, logic c = 1'b1);
    cs = c; wr = 1; rd = 0; a0 = a; wd = d; step();
    cs = 0; wr = 0; step();
  endtask

  task automatic rd_b(logic a);
    cs = 1; rd = 1; wr = 0; a0 = a; irr = 8'h3C; isr = 8'h81; step();
    cs = 0; rd = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    m_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {done, ltim, sngl, vb, cas, sfnm, bufm, mst, aeoi, upm, mask, cv, smm, ris, poll}, 0);
    rst_n = 1; step();
    // R10 writes before setup and with cs low
    wr_b(1, 8'hFF);
    wr_b(0, 8'h20);
    chk("R10 pre-init mask", mask, 0);
    chk("R10 pre-init cmd", cv, 0);
    wr_b(0, 8'h13, 1'b0);
    chk("R10 cs low", done | ltim | sngl, 0);
    // single, fourth word present
    wr_b(0, 8'h13);
    wr_b(0, 8'h20);             // R11 ignored in setup
    chk("R11 no advance", done, 0);
    wr_b(1, 8'h18);
    chk("R3 vec_base 3", vb, 3);
    wr_b(1, 8'h0D);
    chk("R5 flags 0D", {sfnm, bufm, mst, aeoi, upm}, 5'h0D);
    chk("R6 done", done, 1);
    wr_b(1, 8'hA5);
    chk("R6 mask A5", mask, 8'hA5);
    wr_b(1, 8'h5A, 1'b0);
    chk("R10 mask held", mask, 8'hA5);
    cs = 1; wr = 1; a0 = 0; wd = 8'hE3; step();
    chk("R7 pulse", {cv, crot, csel, ceoi, lvl}, 7'b1_111_011);
    cs = 0; wr = 0; step();
    chk("R7 one cycle", cv, 0);
    wr_b(0, 8'h0B);
    rd_b(0);
    chk("R9 isr read", rdata, 8'h81);
    rd_b(1);
    chk("R9 mask read", rdata, 8'hA5);
    wr_b(0, 8'h09);             // RR=0 so ris kept
    chk("R8 ris kept", ris, 1);
    wr_b(0, 8'h0A);
    rd_b(0);
    chk("R9 irr read", rdata, 8'h3C);
    wr_b(0, 8'h28);             // ESMM=0
    chk("R8 smm kept", smm, 0);
    wr_b(0, 8'h68);
    chk("R8 smm set", smm, 1);
    cs = 1; wr = 1; a0 = 0; wd = 8'h0C; step();
    chk("R8 poll pulse", poll, 1);
    cs = 0; wr = 0; step();
    // single without fourth word: flags cleared
    wr_b(0, 8'h1A);
    chk("R2 restart", done, 0);
    chk("R5 cleared", {sfnm, bufm, mst, aeoi, upm}, 0);
    wr_b(1, 8'hF8);
    chk("R5 skip w4", done, 1);
    chk("R2 level", ltim, 1);
    // cascade with both words, restart mid-sequence
    wr_b(0, 8'h11);
    wr_b(1, 8'h40);
    wr_b(0, 8'h11);
    chk("R2 mid restart", done, 0);
    wr_b(1, 8'h48);
    chk("R4 w3 pending", done, 0);
    wr_b(1, 8'h04);
    chk("R4 cas 04", cas, 8'h04);
    wr_b(1, 8'h03);
    chk("R5 flags 03", {sfnm, bufm, mst, aeoi, upm}, 5'h03);
    chk("R3 vb 9", vb, 9);
    // pseudo-random traffic
    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      cs = lcg[31]; wr = lcg[30]; rd = lcg[29]; a0 = lcg[28];
      wd = lcg[27:20]; irr = lcg[19:12]; isr = lcg[11:4];
      if (lcg[3:1] == 0) wd[4] = 1'b1; else if (lcg[3:1] < 5) wd[4] = 1'b0;
      step();
    end
    cs = 0; wr = 0; rd = 0; step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule